// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This block turns a logical address into a linear address. The logical address is a 16-bit segment selector and a 32-bit offset. The segment descriptor that the selector names has already been fetched and arrives as a 64-bit word next to the selector. The block splits the selector into its fields and takes the descriptor apart into base, limit, scaling and access bits. It then checks that the access is legal, and either returns the base plus the offset or returns a fault code.

One request is taken per cycle through a valid/ready handshake. The checks and the add are done in one combinational pass. The result is held in a single output register until the consumer accepts it. When a check fails, the block reports a 3-bit fault code and drives the linear address to zero.

Top module: `seg_xlate`

## Requirements
- R1: Selector fields are bit 15..3 index, bit 2 table select (0 = global table, 1 = local table) and bit 1..0 requested privilege. Descriptor fields are limit[15:0] = bits 15..0, base[23:0] = bits 39..16, access-rights byte = bits 47..40, limit[19:16] = bits 51..48, granularity = bit 55 and base[31:24] = bits 63..56. In the access-rights byte: bit 41 is write-enable for data and read-enable for code, bit 42 is expand-down for data, bit 43 is executable, bit 44 is S (1 = code/data, 0 = system) and bit 47 is present. On success the linear address is base + offset modulo 2^32 and the fault code is 0.
- R2: A selector with index 0 and table select 0 gives fault code 1. Index 0 with table select 1 is not null.
- R3: A non-null selector whose descriptor has present = 0 gives fault code 2.
- R4: A present descriptor with S = 0 gives fault code 3.
- R5: The effective limit is the 20-bit limit when granularity is 0. When granularity is 1 it is the limit shifted left by 12 with the low 12 bits set to one.
- R6: For code segments and expand-up data segments, an offset above the effective limit gives fault code 4. For expand-down data segments, an offset at or below the effective limit gives fault code 4.
- R7: Access kinds are 0 = read, 1 = write, 2 = execute, and 3 is treated as read. A write to read-only data or to any code segment gives fault code 5. A read of code with bit 41 = 0 gives fault code 6. Executing a data segment gives fault code 7.
- R8: Faults are prioritised null > not present > system > limit > permission. A limit fault is reported in place of a permission fault.
- R9: Whenever the fault code is nonzero, the linear address output is zero.
- R10: A request is accepted when in_valid and in_ready are both high, and its result is valid on the next cycle. While out_valid is high and out_ready is low, the result holds and in_ready is low. After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| sel | input | 16 | Segment selector |
| offset | input | 32 | Effective address within the segment |
| desc | input | 64 | Fetched segment descriptor |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 read |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| lin_addr | output | 32 | Linear address, zero on fault |
| fault | output | 3 | Fault code, 0 = none |

## Verification
Random descriptors are drawn with both granularity settings, both expansion directions, both code and data types and all access kinds. Offsets are placed within a few bytes of the effective limit, so that an off-by-one or a swapped comparison direction shows up as the wrong fault code. Directed cases cover the two forms of selector index 0, the absent and system descriptors, and faults that could be reported at two levels, which separates a correct priority order from a reversed one. A stall case holds out_ready low to show that the result stays stable and the input side is blocked.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_NULL    = 3'd1,
    FLT_ABSENT  = 3'd2,
    FLT_SYSTEM  = 3'd3,
    FLT_BOUND   = 3'd4,
    FLT_NOWRITE = 3'd5,
    FLT_NOREAD  = 3'd6,
    FLT_NOEXEC  = 3'd7
  } flt_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  typedef struct packed {
    logic [31:0] base;
    logic [19:0] limit;
    logic        gran;
    logic        present;
    logic        code_data;
    logic        exec;
    logic        dir_conf;
    logic        rw_ok;
  } seg_desc_t;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode #(
  parameter int SEL_W = 16,
  parameter int RPL_W = 2
) (
  input  logic [SEL_W-1:0]       sel,
  output logic [SEL_W-RPL_W-2:0] index,
  output logic                   local_tbl,
  output logic                   is_null
);
  localparam int IDX_LSB = RPL_W + 1;

  logic [RPL_W-1:0] unused_rpl;

  assign unused_rpl = sel[RPL_W-1:0];
  assign local_tbl  = sel[RPL_W];
  assign index      = sel[SEL_W-1:IDX_LSB];
  assign is_null    = (index == '0) && !local_tbl;
endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
  import seg_xlate_pkg::*;
(
  input  logic [63:0] desc,
  output seg_desc_t   fields
);
  logic [5:0] unused_bits;

  assign unused_bits = {desc[40], desc[46:45], desc[54:52]};

  always_comb begin
    fields.base      = {desc[63:56], desc[39:16]};
    fields.limit     = {desc[51:48], desc[15:0]};
    fields.gran      = desc[55];
    fields.present   = desc[47];
    fields.code_data = desc[44];
    fields.exec      = desc[43];
    fields.dir_conf  = desc[42];
    fields.rw_ok     = desc[41];
  end
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check #(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 20
) (
  input  logic [ADDR_W-1:0] off,
  input  logic [LIM_W-1:0]  limit,
  input  logic              gran,
  input  logic              expand_down,
  output logic              in_bounds
);
  localparam int SCALE = ADDR_W - LIM_W;

  logic [ADDR_W-1:0] eff_limit;

  always_comb begin
    if (gran) eff_limit = {limit, {SCALE{1'b1}}};
    else      eff_limit = {{SCALE{1'b0}}, limit};
  end

  assign in_bounds = expand_down ? (off > eff_limit) : (off <= eff_limit);
endmodule

// File: rtl/seg_perm_check.sv
module seg_perm_check
  import seg_xlate_pkg::*;
(
  input  logic [1:0] acc_kind,
  input  logic       exec,
  input  logic       rw_ok,
  output flt_e       perm_flt
);
  always_comb begin
    perm_flt = FLT_NONE;
    if (exec) begin
      case (acc_kind)
        ACC_WRITE: perm_flt = FLT_NOWRITE;
        ACC_EXEC:  perm_flt = FLT_NONE;
        default:   perm_flt = rw_ok ? FLT_NONE : FLT_NOREAD;
      endcase
    end else begin
      case (acc_kind)
        ACC_WRITE: perm_flt = rw_ok ? FLT_NONE : FLT_NOWRITE;
        ACC_EXEC:  perm_flt = FLT_NOEXEC;
        default:   perm_flt = FLT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DESC_W = 64,
  parameter int LIM_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] offset,
  input  logic [DESC_W-1:0] desc,
  input  logic [1:0]        acc_kind,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] lin_addr,
  output logic [2:0]        fault
);
  localparam int IDX_W = SEL_W - 3;

  logic [IDX_W-1:0]  sel_index;
  logic              sel_local;
  logic              sel_null;
  seg_desc_t         dfields;
  logic              bound_ok;
  flt_e              perm_flt;
  flt_e              nxt_flt;
  logic [ADDR_W-1:0] sum_addr;
  logic              accept;

  seg_sel_decode #(.SEL_W(SEL_W), .RPL_W(2)) u_sel (
    .sel       (sel),
    .index     (sel_index),
    .local_tbl (sel_local),
    .is_null   (sel_null)
  );

  seg_desc_unpack u_desc (
    .desc   (desc),
    .fields (dfields)
  );

  seg_limit_check #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_lim (
    .off         (offset),
    .limit       (dfields.limit),
    .gran        (dfields.gran),
    .expand_down (!dfields.exec && dfields.dir_conf),
    .in_bounds   (bound_ok)
  );

  seg_perm_check u_perm (
    .acc_kind (acc_kind),
    .exec     (dfields.exec),
    .rw_ok    (dfields.rw_ok),
    .perm_flt (perm_flt)
  );

  assign sum_addr = dfields.base + offset;

  always_comb begin
    if (sel_null)                nxt_flt = FLT_NULL;
    else if (!dfields.present)   nxt_flt = FLT_ABSENT;
    else if (!dfields.code_data) nxt_flt = FLT_SYSTEM;
    else if (!bound_ok)          nxt_flt = FLT_BOUND;
    else                         nxt_flt = perm_flt;
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      lin_addr  <= '0;
      fault     <= FLT_NONE;
    end else if (accept) begin
      out_valid <= 1'b1;
      fault     <= nxt_flt;
      lin_addr  <= (nxt_flt == FLT_NONE) ? sum_addr : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [15:0] sel,
  input logic [31:0] offset,
  input logic [63:0] desc,
  input logic [1:0]  acc_kind,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] lin_addr,
  input logic [2:0]  fault
);
  assert_null_sel_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && sel[15:3] == 13'd0 && !sel[2])
      |=> (out_valid && fault == 3'd1));

  assert_absent_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (sel[15:3] != 13'd0 || sel[2]) && !desc[47])
      |=> (out_valid && fault == 3'd2));

  assert_fault_zero_addr_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && fault != 3'd0) |-> (lin_addr == 32'd0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready)
      |=> (out_valid && $stable(lin_addr) && $stable(fault)));

  assert_block_input_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind seg_xlate seg_xlate_chk u_chk (.*);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] sel;
  logic [31:0] offset;
  logic [63:0] desc;
  logic [1:0]  acc_kind;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] lin_addr;
  logic [2:0]  fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .sel(sel), .offset(offset), .desc(desc), .acc_kind(acc_kind),
    .out_valid(out_valid), .out_ready(out_ready),
    .lin_addr(lin_addr), .fault(fault)
  );

  function automatic logic [63:0] mk_desc(logic [31:0] base, logic [19:0] lim,
      logic g, logic p, logic s, logic e, logic b2, logic b1);
    logic [63:0] d;
    d = '0;
    d[15:0]  = lim[15:0];
    d[39:16] = base[23:0];
    d[41]    = b1;
    d[42]    = b2;
    d[43]    = e;
    d[44]    = s;
    d[47]    = p;
    d[51:48] = lim[19:16];
    d[55]    = g;
    d[63:56] = base[31:24];
    return d;
  endfunction

  function automatic logic [31:0] eff_lim(logic [63:0] d);
    logic [19:0] l;
    l = {d[51:48], d[15:0]};
    return d[55] ? {l, 12'hfff} : {12'h000, l};
  endfunction

  function automatic logic [34:0] model(logic [15:0] s, logic [31:0] o,
      logic [63:0] d, logic [1:0] k);
    logic [2:0]  f;
    logic [31:0] el;
    logic        ok;
    logic        is_code;
    el = eff_lim(d);
    is_code = d[43];
    if (!is_code && d[42]) ok = (o > el);
    else                   ok = (o <= el);
    if (s[15:3] == 0 && !s[2]) f = 3'd1;
    else if (!d[47])           f = 3'd2;
    else if (!d[44])           f = 3'd3;
    else if (!ok)              f = 3'd4;
    else if (is_code) begin
      if (k == 2'd1)                 f = 3'd5;
      else if (k == 2'd2)            f = 3'd0;
      else                           f = d[41] ? 3'd0 : 3'd6;
    end else begin
      if (k == 2'd1)                 f = d[41] ? 3'd0 : 3'd5;
      else if (k == 2'd2)            f = 3'd7;
      else                           f = 3'd0;
    end
    return {f, (f == 0) ? ({d[63:56], d[39:16]} + o) : 32'd0};
  endfunction

  task automatic check(string req, logic [34:0] act, logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got fault=%0d addr=%h, expected fault=%0d addr=%h",
               req, act[34:32], act[31:0], exp[34:32], exp[31:0]);
    end
  endtask

  task automatic run(string req, logic [15:0] s, logic [31:0] o,
      logic [63:0] d, logic [1:0] k);
    @(negedge clk);
    sel = s; offset = o; desc = d; acc_kind = k; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {34'd0, out_valid}, 35'd1);
    check(req, {fault, lin_addr}, model(s, o, d, k));
  endtask

  localparam logic [15:0] GSEL = 16'h0018;

  initial begin
    logic [63:0] dA;
    logic [63:0] dB;
    void'($urandom(32'h0005_eed1));
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    sel = '0; offset = '0; desc = '0; acc_kind = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    check("R10 reset", {33'd0, out_valid, in_ready}, 35'b01);

    // R1 plain translation
    dA = mk_desc(32'h1234_5000, 20'h0ffff, 0, 1, 1, 0, 0, 1);
    run("R1", GSEL, 32'h0000_0abc, dA, 2'd0);
    check("R1 addr", {fault, lin_addr}, {3'd0, 32'h1234_5abc});
    run("R1 wrap", GSEL, 32'hffff_fff0, mk_desc(32'h0000_0020, 20'hfffff, 1, 1, 1, 0, 0, 1), 2'd3);
    // R2 null selector forms
    run("R2 null", 16'h0003, 32'd0, dA, 2'd0);
    run("R2 local idx0", 16'h0004, 32'd0, dA, 2'd0);
    // R3, R4
    run("R3 absent", GSEL, 32'd0, mk_desc(0, 20'hfff, 0, 0, 1, 0, 0, 1), 2'd0);
    run("R4 system", GSEL, 32'd0, mk_desc(0, 20'hfff, 0, 1, 0, 0, 0, 1), 2'd0);
    // R5 granularity scaling
    run("R5 g1 top", GSEL, 32'h0000_0fff, mk_desc(0, 20'h0, 1, 1, 1, 0, 0, 1), 2'd0);
    run("R5 g1 over", GSEL, 32'h0000_1000, mk_desc(0, 20'h0, 1, 1, 1, 0, 0, 1), 2'd0);
    run("R5 g0 over", GSEL, 32'h0000_0001, mk_desc(0, 20'h0, 0, 1, 1, 0, 0, 1), 2'd0);
    // R6 expand-up and expand-down boundaries
    run("R6 up eq", GSEL, 32'h100, mk_desc(0, 20'h100, 0, 1, 1, 0, 0, 1), 2'd1);
    run("R6 up over", GSEL, 32'h101, mk_desc(0, 20'h100, 0, 1, 1, 0, 0, 1), 2'd1);
    run("R6 down eq", GSEL, 32'h100, mk_desc(0, 20'h100, 0, 1, 1, 0, 1, 1), 2'd1);
    run("R6 down above", GSEL, 32'h101, mk_desc(0, 20'h100, 0, 1, 1, 0, 1, 1), 2'd1);
    run("R6 code conforming", GSEL, 32'h80, mk_desc(0, 20'h100, 0, 1, 1, 1, 1, 1), 2'd2);
    // R7 permissions
    run("R7 write ro", GSEL, 32'h10, mk_desc(0, 20'h100, 0, 1, 1, 0, 0, 0), 2'd1);
    run("R7 read xo", GSEL, 32'h10, mk_desc(0, 20'h100, 0, 1, 1, 1, 0, 0), 2'd0);
    run("R7 write code", GSEL, 32'h10, mk_desc(0, 20'h100, 0, 1, 1, 1, 0, 1), 2'd1);
    run("R7 exec data", GSEL, 32'h10, mk_desc(0, 20'h100, 0, 1, 1, 0, 0, 1), 2'd2);
    // R8 priority
    run("R8 limit over perm", GSEL, 32'h200, mk_desc(0, 20'h100, 0, 1, 1, 0, 0, 0), 2'd1);
    run("R8 absent over system", GSEL, 32'h0, mk_desc(0, 20'h100, 0, 0, 0, 0, 0, 0), 2'd1);

    // R10 stall
    @(negedge clk) out_ready = 1'b0;
    dB = mk_desc(32'h0004_0000, 20'h00fff, 0, 1, 1, 0, 0, 1);
    run("R10 first", GSEL, 32'h44, dB, 2'd0);
    @(negedge clk);
    sel = GSEL; offset = 32'h55; desc = dB; acc_kind = 2'd0; in_valid = 1'b1;
    check("R10 blocked", {34'd0, in_ready}, 35'd0);
    @(negedge clk);
    check("R10 hold", {fault, lin_addr}, {3'd0, 32'h0004_0044});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second", {fault, lin_addr}, {3'd0, 32'h0004_0055});

    // random, offsets near the effective limit (R5 R6 R7 R9)
    for (int i = 0; i < 600; i++) begin
      logic [63:0] d;
      logic [15:0] s;
      logic [31:0] o;
      d = mk_desc($urandom, $urandom, $urandom_range(0, 1), ($urandom_range(0, 15) != 0),
                  ($urandom_range(0, 15) != 0), $urandom_range(0, 1),
                  $urandom_range(0, 1), $urandom_range(0, 1));
      s = ($urandom_range(0, 31) == 0) ? {13'd0, $urandom_range(0, 7)} : $urandom;
      case ($urandom_range(0, 2))
        0: o = eff_lim(d) + $urandom_range(0, 3) - 32'd1;
        1: o = eff_lim(d) >> $urandom_range(1, 8);
        default: o = $urandom;
      endcase
      run("R9 random", s, o, d, $urandom_range(0, 3));
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule